// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block is the command side of an SD/MMC host controller. Software supplies a 32-bit argument and writes a 16-bit command word. If the controller is enabled and no command is outstanding, the block does four things: it clears the response registers, decodes the word, raises a request to the card side carrying the command index and argument, and holds that request until the card acknowledges. The serial CMD line and CRC handling are not part of this block. A parallel handshake stands in for the card. With the acknowledge, the card returns a byte count and a response window that is big-endian and left-aligned.

When the acknowledge arrives, the block compares the returned length with the length that the declared response type needs. It then checks card error bits for the given type, samples the OCR busy bit for R3, updates the command status bits and stores the response. The interrupt output is the OR of status ANDed with an enable mask. Software clears status by writing 1s to it. A command of the data-carrying type opens a data-transfer window in the stated direction. Any other command type closes that window.

Top module: `sdcmd_host`

## Requirements
- R1: Command word fields are: index in bits 5:0, init in bit 7, response type in bits 10:8, busy in bit 11, command type in bits 13:12 and direction in bit 15 (1 = read). An accepted command drives `card_idx_o` with the index and `card_arg_o` with the argument latched at acceptance. `card_req_o` stays high until the cycle in which `card_ack_i` is high.
- R2: A command write while `en_i` is low is ignored. No request is raised, and the response registers and status keep their values.
- R3: A command with the init bit set and index 0 raises no request. In the cycle after the write it sets status bit 0. A command with the init bit set and a nonzero index is sent normally.
- R4: If `card_len_i` is below the byte count the type needs (4 for R1, R1b, R3 and R6; 2·NUM_RSP for R2), status bit 7 (timeout) is set and status bit 0 is not set.
- R5: For R1 and R1b (type 1, busy bit 0 or 1), response bytes 0..3 form a big-endian word. If any bit of that word under mask 0xFDF90000 is set, status bit 14 is set. Otherwise status bit 14 is cleared.
- R6: For R6 (type 6), status bit 14 follows bits 15:13 of the big-endian 16-bit value in response bytes 2..3. Bytes 0..1 are ignored.
- R7: For R3 (type 3), status bit 12 is set when bit 31 of response bytes 0..3 is 0, and cleared when that bit is 1.
- R8: A command that completes without timeout sets status bit 0. Index 12 also sets status bit 2.
- R9: Response bytes 2k and 2k+1 go to response register 7−k, with the first byte of each pair as the high byte. Register j appears at `rsp_flat_o[16j+15:16j]`. All registers clear when a command is accepted. A response is stored only when the type is not "none" and there is no timeout.
- R10: An accepted command of type 3 sets `xfer_active_o` and copies bit 15 to `xfer_read_o`. Any other type clears `xfer_active_o`.
- R11: Each 1 in `stat_w1c_i` clears that status bit. `irq_o` is high when any status bit is set whose bit in the 15-bit mask is also set.
- R12: A command write while a request is outstanding is ignored, and the outstanding index and argument are unchanged.
- R13: Response type codes 0, 4, 5 and 7 are treated as "no response". Completion sets status bit 0 and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Controller enable |
| arg_i | input | ARG_W | Command argument |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 16 | Command word |
| stat_w1c_i | input | 16 | Status write-1-to-clear bits |
| mask_we_i | input | 1 | Interrupt mask write strobe |
| mask_i | input | 16 | Interrupt mask (bit 15 dropped) |
| card_req_o | output | 1 | Request to card side |
| card_idx_o | output | 6 | Command index to card |
| card_arg_o | output | ARG_W | Argument to card |
| card_ack_i | input | 1 | Card response valid |
| card_len_i | input | LEN_W | Number of response bytes returned |
| card_rsp_i | input | 16·NUM_RSP | Response bytes, byte 0 in the top byte |
| status_o | output | 16 | Status register |
| irq_o | output | 1 | Interrupt |
| rsp_flat_o | output | 16·NUM_RSP | Response registers, register j at bits 16j+15:16j |
| xfer_active_o | output | 1 | Data transfer window open |
| xfer_read_o | output | 1 | Data transfer direction (1 = read) |

## Verification
The bench uses the defaults NUM_RSP = 8 and ARG_W = 32. With these, the full 16-byte R2 window and its 15/16 length boundary can be tested, as can the 3/4 boundary for short responses. Eight response registers are also enough to show the reversed pair order over the whole window. The wide argument makes stale-argument errors visible when a second write is attempted during a pending request.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int CW_W  = 16;
  localparam int IDX_W = 6;

  // status bit positions
  localparam int ST_END  = 0;
  localparam int ST_STOP = 2;
  localparam int ST_CTO  = 7;
  localparam int ST_BUSY = 12;
  localparam int ST_CERR = 14;

  localparam logic [1:0]       CT_DATA  = 2'd3;
  localparam logic [IDX_W-1:0] STOP_IDX = 6'd12;
  localparam logic [31:0]      R1_ERR   = 32'hFDF9_0000;
  localparam logic [15:0]      R6_ERR   = 16'hE000;

  typedef enum logic [2:0] {RK_NONE, RK_R1, RK_R1B, RK_R2, RK_R3, RK_R6} rsp_kind_e;

  typedef struct packed {
    logic             dir;
    logic             rsv14;
    logic [1:0]       ctype;
    logic             busy;
    logic [2:0]       rtype;
    logic             init;
    logic             rsv6;
    logic [IDX_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic [CW_W-1:0] word_i,
  output cmd_t            cmd_o,
  output rsp_kind_e       kind_o,
  output logic            boot_o
);
  assign cmd_o  = cmd_t'(word_i);
  assign boot_o = cmd_o.init && (cmd_o.idx == '0);

  always_comb begin
    unique case (cmd_o.rtype)
      3'd1:    kind_o = cmd_o.busy ? RK_R1B : RK_R1;
      3'd2:    kind_o = RK_R2;
      3'd3:    kind_o = RK_R3;
      3'd6:    kind_o = RK_R6;
      default: kind_o = RK_NONE;
    endcase
  end
endmodule

// File: rtl/sdcmd_rsp_check.sv
module sdcmd_rsp_check
  import sdcmd_pkg::*;
#(
  parameter  int NUM_RSP = 8,
  localparam int RSP_W   = NUM_RSP * 16,
  localparam int LEN_W   = $clog2(NUM_RSP * 2 + 1)
) (
  input  rsp_kind_e        kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [RSP_W-1:0] rsp_i,
  output logic [CW_W-1:0]  set_o,
  output logic [CW_W-1:0]  clr_o,
  output logic             store_o
);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(NUM_RSP * 2);

  logic [31:0]      head;
  logic [LEN_W-1:0] need;
  logic             tmo, cerr;

  assign head = rsp_i[RSP_W-1 -: 32];

  always_comb begin
    unique case (kind_i)
      RK_NONE: need = '0;
      RK_R2:   need = LEN_LONG;
      default: need = LEN_SHORT;
    endcase
    tmo = len_i < need;

    unique case (kind_i)
      RK_R1, RK_R1B: cerr = |(head & R1_ERR);
      RK_R6:         cerr = |(head[15:0] & R6_ERR);
      default:       cerr = 1'b0;
    endcase
    if (tmo) cerr = 1'b0;

    set_o = '0;
    clr_o = '0;
    if (tmo) set_o[ST_CTO] = 1'b1;
    else begin
      set_o[ST_END] = 1'b1;
      if (idx_i == STOP_IDX) set_o[ST_STOP] = 1'b1;
    end
    if (cerr) set_o[ST_CERR] = 1'b1;
    else      clr_o[ST_CERR] = 1'b1;
    if (kind_i == RK_R3 && !tmo) begin
      if (head[31]) clr_o[ST_BUSY] = 1'b1;
      else          set_o[ST_BUSY] = 1'b1;
    end
    store_o = (kind_i != RK_NONE) && !tmo;
  end
endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status
  import sdcmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW_W-1:0] set_i,
  input  logic [CW_W-1:0] clr_i,
  input  logic [CW_W-1:0] w1c_i,
  input  logic            mask_we_i,
  input  logic [CW_W-1:0] mask_i,
  output logic [CW_W-1:0] status_o,
  output logic            irq_o
);
  localparam int MASK_W = CW_W - 1;

  logic [CW_W-1:0]   status_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      // event sets win over software clears in the same cycle
      status_q <= (status_q & ~w1c_i & ~clr_i) | set_i;
      if (mask_we_i) mask_q <= mask_i[MASK_W-1:0];
    end
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q[MASK_W-1:0] & mask_q);

  // R11
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_i != '0 && set_i == '0 && clr_i == '0) |=> ((status_o & $past(w1c_i)) == '0));

  // R11
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && mask_i[MASK_W-1:0] == '0) |=> !irq_o);
endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
  import sdcmd_pkg::*;
#(
  parameter  int ARG_W   = 32,
  parameter  int NUM_RSP = 8,
  localparam int RSP_W   = NUM_RSP * 16,
  localparam int LEN_W   = $clog2(NUM_RSP * 2 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             cmd_we_i,
  input  logic [15:0]      cmd_word_i,
  input  logic [15:0]      stat_w1c_i,
  input  logic             mask_we_i,
  input  logic [15:0]      mask_i,
  output logic             card_req_o,
  output logic [5:0]       card_idx_o,
  output logic [ARG_W-1:0] card_arg_o,
  input  logic             card_ack_i,
  input  logic [LEN_W-1:0] card_len_i,
  input  logic [RSP_W-1:0] card_rsp_i,
  output logic [15:0]      status_o,
  output logic             irq_o,
  output logic [RSP_W-1:0] rsp_flat_o,
  output logic             xfer_active_o,
  output logic             xfer_read_o
);
  typedef enum logic {S_IDLE, S_WAIT} state_e;

  state_e           state_q;
  cmd_t             dec_cmd;
  rsp_kind_e        dec_kind, kind_q;
  logic             dec_boot;
  logic [IDX_W-1:0] idx_q;
  logic [ARG_W-1:0] arg_q;
  logic             xfer_q, xdir_q;
  logic             accept, launch, done;
  logic [CW_W-1:0]  chk_set, chk_clr, st_set, st_clr;
  logic             chk_store;

  sdcmd_decode u_dec (
    .word_i (cmd_word_i),
    .cmd_o  (dec_cmd),
    .kind_o (dec_kind),
    .boot_o (dec_boot)
  );

  sdcmd_rsp_check #(.NUM_RSP(NUM_RSP)) u_chk (
    .kind_i  (kind_q),
    .idx_i   (idx_q),
    .len_i   (card_len_i),
    .rsp_i   (card_rsp_i),
    .set_o   (chk_set),
    .clr_o   (chk_clr),
    .store_o (chk_store)
  );

  assign accept = cmd_we_i && en_i && (state_q == S_IDLE);
  assign launch = accept && !dec_boot;
  assign done   = (state_q == S_WAIT) && card_ack_i;

  always_comb begin
    st_set = done ? chk_set : '0;
    st_clr = done ? chk_clr : '0;
    if (accept && dec_boot) st_set[ST_END] = 1'b1;
  end

  sdcmd_status u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (st_set),
    .clr_i     (st_clr),
    .w1c_i     (stat_w1c_i),
    .mask_we_i (mask_we_i),
    .mask_i    (mask_i),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= RK_NONE;
      idx_q   <= '0;
      arg_q   <= '0;
      xfer_q  <= 1'b0;
      xdir_q  <= 1'b0;
    end else if (launch) begin
      state_q <= S_WAIT;
      kind_q  <= dec_kind;
      idx_q   <= dec_cmd.idx;
      arg_q   <= arg_i;
      xfer_q  <= (dec_cmd.ctype == CT_DATA);
      if (dec_cmd.ctype == CT_DATA) xdir_q <= dec_cmd.dir;
    end else if (done) begin
      state_q <= S_IDLE;
    end
  end

  for (genvar g = 0; g < NUM_RSP; g++) begin : g_rsp
    logic [15:0] rsp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                rsp_q <= '0;
      else if (accept)            rsp_q <= '0;
      else if (done && chk_store) rsp_q <= card_rsp_i[16*g +: 16];
    end
    assign rsp_flat_o[16*g +: 16] = rsp_q;
  end

  assign card_req_o    = (state_q == S_WAIT);
  assign card_idx_o    = idx_q;
  assign card_arg_o    = arg_q;
  assign xfer_active_o = xfer_q;
  assign xfer_read_o   = xdir_q;

  // R1
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_req_o && !card_ack_i) |=> card_req_o);

  // R12
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_req_o && !card_ack_i) |=> ($stable(card_idx_o) && $stable(card_arg_o)));

  // R2
  dis_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_req_o && !en_i) |=> (!card_req_o && $stable(rsp_flat_o)));

  // R3
  boot_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_req_o && cmd_we_i && en_i && cmd_word_i[7] && cmd_word_i[5:0] == 6'd0)
      |=> (!card_req_o && status_o[0]));

  // R9
  rsp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_req_o && cmd_we_i && en_i) |=> (rsp_flat_o == '0));
endmodule

// File: tb/sim_sdcmd_host.sv
module sim_sdcmd_host;
  localparam int ARG_W   = 32;
  localparam int NUM_RSP = 8;
  localparam int RSP_W   = NUM_RSP * 16;
  localparam int LEN_W   = $clog2(NUM_RSP * 2 + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b1;
  logic [ARG_W-1:0] arg = '0;
  logic             cmd_we = 1'b0;
  logic [15:0]      cmd_word = '0;
  logic [15:0]      w1c = '0;
  logic             mask_we = 1'b0;
  logic [15:0]      mask = '0;
  logic             card_req;
  logic [5:0]       card_idx;
  logic [ARG_W-1:0] card_arg;
  logic             card_ack = 1'b0;
  logic [LEN_W-1:0] card_len = '0;
  logic [RSP_W-1:0] card_rsp = '0;
  logic [15:0]      status;
  logic             irq;
  logic [RSP_W-1:0] rsp_flat;
  logic             xfer_active, xfer_read;

  sdcmd_host #(.ARG_W(ARG_W), .NUM_RSP(NUM_RSP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .arg_i(arg),
    .cmd_we_i(cmd_we), .cmd_word_i(cmd_word), .stat_w1c_i(w1c),
    .mask_we_i(mask_we), .mask_i(mask),
    .card_req_o(card_req), .card_idx_o(card_idx), .card_arg_o(card_arg),
    .card_ack_i(card_ack), .card_len_i(card_len), .card_rsp_i(card_rsp),
    .status_o(status), .irq_o(irq), .rsp_flat_o(rsp_flat),
    .xfer_active_o(xfer_active), .xfer_read_o(xfer_read)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [3:0]  rq;
    logic [15:0] cmd;
    logic [4:0]  len;
    logic [31:0] w0;
    logic [15:0] st;
    logic        keep;
  } vec_t;

  localparam int NV = 14;
  // R8 R5 R4 R9 R7 R6 R13 cases
  localparam vec_t VECS [NV] = '{
    '{4'd8,  16'h0111, 5'd4,  32'h0000_0900, 16'h0001, 1'b1},
    '{4'd5,  16'h0111, 5'd4,  32'h8000_0000, 16'h4001, 1'b1},
    '{4'd5,  16'h010D, 5'd4,  32'h0200_0000, 16'h0001, 1'b1},
    '{4'd4,  16'h0111, 5'd3,  32'h0000_0000, 16'h0080, 1'b0},
    '{4'd9,  16'h0202, 5'd16, 32'h3F12_3456, 16'h0001, 1'b1},
    '{4'd4,  16'h0202, 5'd15, 32'h3F12_3456, 16'h0080, 1'b0},
    '{4'd7,  16'h0329, 5'd4,  32'h00FF_8000, 16'h1001, 1'b1},
    '{4'd6,  16'h0603, 5'd4,  32'h1234_2000, 16'h4001, 1'b1},
    '{4'd6,  16'h0603, 5'd4,  32'hFFFF_1FFF, 16'h0001, 1'b1},
    '{4'd8,  16'h090C, 5'd4,  32'h0000_0000, 16'h0005, 1'b1},
    '{4'd5,  16'h0907, 5'd4,  32'h0040_0000, 16'h4001, 1'b1},
    '{4'd9,  16'h0000, 5'd16, 32'hDEAD_BEEF, 16'h0001, 1'b0},
    '{4'd13, 16'h0409, 5'd16, 32'hDEAD_BEEF, 16'h0001, 1'b0},
    '{4'd4,  16'h0603, 5'd2,  32'h0000_0000, 16'h0080, 1'b0}
  };

  function automatic logic [95:0] fill(input int i);
    return {3{32'hA5C3_0000 | 32'(i)}};
  endfunction

  task automatic chk(input string tag, input logic [RSP_W-1:0] act, input logic [RSP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic [ARG_W-1:0] a);
    @(negedge clk);
    cmd_we = 1'b1; cmd_word = w; arg = a;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic respond(input logic [LEN_W-1:0] len, input logic [RSP_W-1:0] r);
    for (int n = 0; n < 50 && !card_req; n++) @(negedge clk);
    card_len = len; card_rsp = r; card_ack = 1'b1;
    @(negedge clk);
    card_ack = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk); w1c = 16'hFFFF;
    @(negedge clk); w1c = 16'h0000;
  endtask

  task automatic set_mask(input logic [15:0] m);
    @(negedge clk); mask_we = 1'b1; mask = m;
    @(negedge clk); mask_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RSP_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset status", status, 0);
    chk("R11 reset irq", irq, 0);
    chk("R1 reset req", card_req, 0);
    chk("R9 reset rsp", rsp_flat, 0);
    chk("R10 reset xfer", xfer_active, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = $sformatf("R%0d vec%0d", v.rq, i);
      clr_all();
      issue(v.cmd, {16'hBEEF, 16'(i)});
      chk({t, " R1 req"}, card_req, 1);
      chk({t, " R1 idx"}, card_idx, v.cmd[5:0]);
      chk({t, " R1 arg"}, card_arg, {16'hBEEF, 16'(i)});
      respond(v.len, {v.w0, fill(i)});
      chk({t, " status"}, status, v.st);
      chk({t, " rsp"}, rsp_flat, v.keep ? {v.w0, fill(i)} : '0);
      chk({t, " R1 req drop"}, card_req, 0);
    end

    // R11 interrupt and write-1-to-clear
    clr_all();
    issue(16'h0111, 32'h1);
    respond(5'd4, {32'h8000_0000, 96'h0});
    set_mask(16'h4000);
    chk("R11 irq on", irq, 1);
    set_mask(16'h0080);
    chk("R11 irq masked", irq, 0);
    set_mask(16'h4000);
    @(negedge clk); w1c = 16'h4000;
    @(negedge clk); w1c = 16'h0000;
    chk("R11 w1c status", status, 16'h0001);
    chk("R11 irq after clear", irq, 0);
    set_mask(16'h0001);
    chk("R11 irq bit0", irq, 1);
    set_mask(16'h0000);

    // R7 busy bit cleared by OCR bit 31
    clr_all();
    issue(16'h0329, 32'h2);
    respond(5'd4, {32'h00FF_8000, 96'h0});
    chk("R7 busy set", status, 16'h1001);
    issue(16'h0329, 32'h3);
    respond(5'd4, {32'h80FF_8000, 96'h0});
    chk("R7 busy cleared", status, 16'h0001);

    // R9 response cleared at acceptance
    issue(16'h0202, 32'h4);
    respond(5'd16, {32'h1122_3344, fill(77)});
    chk("R9 r2 stored", rsp_flat, {32'h1122_3344, fill(77)});
    issue(16'h0111, 32'h5);
    chk("R9 cleared while pending", rsp_flat, 0);
    respond(5'd4, {32'h0000_0100, fill(78)});
    held = {32'h0000_0100, fill(78)};

    // R2 disabled write ignored
    clr_all();
    en = 1'b0;
    issue(16'h0202, 32'h6);
    chk("R2 no req", card_req, 0);
    chk("R2 rsp kept", rsp_flat, held);
    chk("R2 status kept", status, 0);
    en = 1'b1;

    // R3 init with index 0
    clr_all();
    issue(16'h0080, 32'h7);
    chk("R3 no req", card_req, 0);
    chk("R3 end set", status, 16'h0001);
    chk("R3 rsp cleared", rsp_flat, 0);
    clr_all();
    issue(16'h0085, 32'h8);
    chk("R3 init nonzero sent", card_req, 1);
    chk("R3 init nonzero idx", card_idx, 5);
    respond(5'd0, '0);
    chk("R3 init nonzero done", status, 16'h0001);

    // R12 write during outstanding request
    issue(16'h0105, 32'hAAAA_0001);
    issue(16'h0109, 32'hBBBB_0002);
    chk("R12 idx kept", card_idx, 5);
    chk("R12 arg kept", card_arg, 32'hAAAA_0001);
    respond(5'd4, '0);
    chk("R12 no second req", card_req, 0);

    // R10 data transfer window
    issue(16'hB111, 32'h9);
    chk("R10 read active", xfer_active, 1);
    chk("R10 read dir", xfer_read, 1);
    respond(5'd4, '0);
    issue(16'h2107, 32'hA);
    chk("R10 closed", xfer_active, 0);
    respond(5'd4, '0);
    issue(16'h3118, 32'hB);
    chk("R10 write active", xfer_active, 1);
    chk("R10 write dir", xfer_read, 0);
    respond(5'd4, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule